// File: doc/BRIEF.md
# Comparator Timer Channel

This block is one event channel of a timer. Each clock it can compare a free-running main counter, supplied from outside, against a programmable comparator. When the counter reaches or passes the comparator, the channel raises a single-cycle expiry pulse. The channel runs either once per arming (one-shot) or repeatedly (periodic). In periodic mode the comparator advances by a stored period after every expiry.

Two comparison widths are offered. In wide mode all 64 bits take part in the test. In narrow mode only the low 32 bits of the counter and comparator are compared. In narrow one-shot operation the channel also raises an extra event when the counter's low half reaches all-ones, ahead of the real match. Software loads the comparator and period 32 bits at a time through two write strobes. A self-clearing "direct load" bit decides whether a write in periodic mode also moves the live comparator. The main counter, interrupt delivery and the register bus all sit outside this block.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset the comparator reads all-ones, the period reads zero, the direct-load bit reads 0 and expire_o is low.
- R2: In wide one-shot mode, expire_o is high for exactly one cycle, in the cycle after the clock edge that sampled tick_i=1 with count_i at or past the comparator. No further pulse comes until the channel is re-armed by a comparator write or by the channel enable rising.
- R3: "At or past" means that the difference comparator minus counter is zero or negative as a two's-complement number. A counter far beyond the comparator therefore fires at once. In narrow mode only bits 31:0 of both values enter this difference.
- R4: In periodic mode with a non-zero period, each expiry adds the period to the comparator. In narrow mode the sum is cut to 32 bits.
- R5: If the comparator is still strictly behind the counter after that addition, one period is added on each following clock until it no longer is. No expiry is raised during this catch-up, so a jump of the counter gives one pulse.
- R6: A low-half write (cmp_wr_lo_i) targets bits 31:0 and a high-half write (cmp_wr_hi_i) targets bits 63:32. The comparator half is loaded when the channel is one-shot, or when the direct-load bit is 1. The period half is loaded whenever the channel is periodic.
- R7: Data written into the period is clamped. In narrow mode bit 31 of the written data is cleared for either half. In wide mode a high-half write clears bit 63 of the period.
- R8: The direct-load bit is set by a configuration write and cleared by the next comparator write of either half. A configuration write in the same cycle wins.
- R9: A configuration write that selects narrow mode clears bits 63:32 of both the comparator and the period.
- R10: In narrow one-shot mode, while armed, a tick with count_i[31:0] all-ones raises one extra expiry before the comparator match; the match still fires afterwards. Each comparator write or channel enable re-arms this wrap detection.
- R11: No expiry is raised in a cycle where tick_i is low, glb_en_i is low, or the stored channel enable is 0. An armed channel keeps its pending match until these allow it.
- R12: In periodic mode with a zero period, the channel fires once and then stays quiet until re-armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | 64 | Current main counter value |
| tick_i | input | 1 | Counter advanced this cycle; comparison is made only then |
| glb_en_i | input | 1 | Global enable for event generation |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Channel enable to store |
| cfg_per_i | input | 1 | Periodic mode to store |
| cfg_nar_i | input | 1 | Narrow (32-bit) mode to store |
| cfg_setval_i | input | 1 | Direct-load bit to store |
| cmp_wr_lo_i | input | 1 | Write strobe for bits 31:0 |
| cmp_wr_hi_i | input | 1 | Write strobe for bits 63:32 |
| cmp_wdata_i | input | 32 | Data for the comparator/period half |
| expire_o | output | 1 | One-cycle expiry pulse |
| cmp_o | output | 64 | Current comparator value |
| period_o | output | 64 | Current period value |
| setval_o | output | 1 | Current direct-load bit |

## Verification
A wrong arming or wrap flag inside the channel shows up as a missing or extra expire_o pulse. It becomes visible at the next tick that meets the comparator or the all-ones point, one cycle after that edge. A wrong catch-up flag either swallows a periodic pulse or adds a second one after a counter jump. It also leaves cmp_o at a value that is not the first multiple of the period ahead of the counter, and this is readable a few clocks after the jump. Errors in the write routing and clamping appear on cmp_o and period_o in the cycle right after the write.

// File: rtl/cmpt_pkg.sv
// Shared types for the comparator timer channel.
// Assumes: none beyond IEEE 1800-2017.
package cmpt_pkg;

    // Stored channel operating mode
    typedef struct packed {
        logic en;   // channel enable
        logic per;  // periodic operation
        logic nar;  // narrow (half-width) comparison
    } cmpt_mode_t;

    // Kind of event raised in a given cycle
    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_MATCH = 2'd1,
        EV_WRAP  = 2'd2
    } cmpt_ev_e;

endpackage

// File: rtl/cmpt_cfg_reg.sv
// Channel configuration register.
// Holds enable, periodic and narrow mode plus the self-clearing direct-load bit.
// Produces the enable-rise pulse and the truncation request for this cycle's
// configuration write.
// Assumes: a configuration write and a comparator write in the same cycle
// leave the direct-load bit at the value written by the configuration.
module cmpt_cfg_reg
    import cmpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr_i,
    input  logic       cfg_en_i,
    input  logic       cfg_per_i,
    input  logic       cfg_nar_i,
    input  logic       cfg_setval_i,
    input  logic       cmp_wr_i,
    output cmpt_mode_t mode_o,
    output logic       setval_o,
    output logic       en_rise_o,
    output logic       trunc_o
);

    cmpt_mode_t mode_q;
    logic       setval_q;

    // Hold mode bits; direct-load bit clears on any comparator write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            setval_q <= 1'b0;
        end else begin
            if (cfg_wr_i) begin
                mode_q.en  <= cfg_en_i;
                mode_q.per <= cfg_per_i;
                mode_q.nar <= cfg_nar_i;
            end
            if (cfg_wr_i) begin
                setval_q <= cfg_setval_i;
            end else if (cmp_wr_i) begin
                setval_q <= 1'b0;
            end
        end
    end

    // Pulses derived from the incoming configuration write
    always_comb begin
        en_rise_o = cfg_wr_i && cfg_en_i && !mode_q.en;
        trunc_o   = cfg_wr_i && cfg_nar_i;
    end

    assign mode_o   = mode_q;
    assign setval_o = setval_q;

    // R8
    setval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cmp_wr_i) && !$past(cfg_wr_i)) |-> !setval_q);

endmodule

// File: rtl/cmpt_cmp_store.sv
// Comparator and period storage.
// Applies periodic advances, narrow-mode truncation and half-word writes with
// period clamping. Later sources win bit by bit: advance, then truncation,
// then the written half.
// Assumes: CNT_W is even; mode_i is the registered mode.
module cmpt_cmp_store
    import cmpt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cmpt_mode_t           mode_i,
    input  logic                 setval_i,
    input  logic                 wr_lo_i,
    input  logic                 wr_hi_i,
    input  logic [CNT_W/2-1:0]   wdata_i,
    input  logic                 trunc_i,
    input  logic                 adv_i,
    output logic [CNT_W-1:0]     cmp_o,
    output logic [CNT_W-1:0]     per_o,
    output logic [CNT_W-1:0]     sum_o
);

    localparam int HALF_W = CNT_W / 2;
    localparam logic [HALF_W-1:0] TOP_CLR = {1'b0, {(HALF_W-1){1'b1}}};

    logic [CNT_W-1:0]  cmp_q;
    logic [CNT_W-1:0]  per_q;
    logic [CNT_W-1:0]  sum_full;
    logic              cmp_sel;
    logic              per_sel;
    logic [HALF_W-1:0] lo_mask;

    // Next comparator for a periodic step, cut to the active width
    always_comb begin
        sum_full = cmp_q + per_q;
        if (mode_i.nar) begin
            sum_o = {{HALF_W{1'b0}}, sum_full[HALF_W-1:0]};
        end else begin
            sum_o = sum_full;
        end
    end

    // Write routing and clamp selection
    always_comb begin
        cmp_sel = !mode_i.per || setval_i;
        per_sel = mode_i.per;
        lo_mask = mode_i.nar ? TOP_CLR : {HALF_W{1'b1}};
    end

    // Comparator and period registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= {CNT_W{1'b1}};
            per_q <= '0;
        end else begin
            if (adv_i) begin
                cmp_q <= sum_o;
            end
            if (trunc_i) begin
                cmp_q[CNT_W-1:HALF_W] <= '0;
                per_q[CNT_W-1:HALF_W] <= '0;
            end
            if (wr_lo_i) begin
                if (cmp_sel) cmp_q[HALF_W-1:0] <= wdata_i;
                if (per_sel) per_q[HALF_W-1:0] <= wdata_i & lo_mask;
            end
            if (wr_hi_i) begin
                if (cmp_sel) cmp_q[CNT_W-1:HALF_W] <= wdata_i;
                if (per_sel) per_q[CNT_W-1:HALF_W] <= wdata_i & TOP_CLR;
            end
        end
    end

    assign cmp_o = cmp_q;
    assign per_o = per_q;

    // R1
    reset_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cmp_q == {CNT_W{1'b1}}) && (per_q == '0));

    // R9
    trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(trunc_i) && !$past(wr_hi_i) && !$past(adv_i))
        |-> (cmp_q[CNT_W-1:HALF_W] == '0) && (per_q[CNT_W-1:HALF_W] == '0));

    // R7
    clamp_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_hi_i) && $past(mode_i.per)) |-> !per_q[CNT_W-1]);

endmodule

// File: rtl/cmpt_expiry.sv
// Expiry decision logic.
// Tests the signed comparator-minus-counter difference on each tick and
// raises match and wrap events. It also runs periodic catch-up, one period
// per clock, and keeps the armed, wrap and catch-up flags.
// Assumes: sum_i is cmp_i plus the period at the active width; arm_i marks a
// comparator write or an enable rise, and an arm suppresses this cycle's advance.
module cmpt_expiry
    import cmpt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             glb_en_i,
    input  cmpt_mode_t       mode_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic [CNT_W-1:0] sum_i,
    input  logic             arm_i,
    output logic             adv_o,
    output logic             expire_o
);

    localparam int HALF_W = CNT_W / 2;

    logic             armed_q;
    logic             wrap_q;
    logic             cu_q;
    logic             expire_q;
    logic [CNT_W-1:0] diff_now;
    logic [CNT_W-1:0] diff_next;
    logic             due;
    logic             behind_next;
    logic             act;
    logic             per_live;
    logic             hit;
    logic             wrap_hit;
    cmpt_ev_e         ev;

    // Zero or negative difference at the active width
    function automatic logic at_or_past(input logic [CNT_W-1:0] d, input logic nar);
        if (nar) return (d[HALF_W-1:0] == '0) || d[HALF_W-1];
        return (d == '0) || d[CNT_W-1];
    endfunction

    // Strictly negative difference at the active width
    function automatic logic strictly_behind(input logic [CNT_W-1:0] d, input logic nar);
        return nar ? d[HALF_W-1] : d[CNT_W-1];
    endfunction

    // Comparison terms for the present and the advanced comparator
    always_comb begin
        diff_now    = cmp_i - count_i;
        diff_next   = sum_i - count_i;
        due         = at_or_past(diff_now, mode_i.nar);
        behind_next = strictly_behind(diff_next, mode_i.nar);
    end

    // Event selection; a match has priority over a wrap
    always_comb begin
        act      = glb_en_i && mode_i.en;
        per_live = mode_i.per && (per_i != '0);
        hit      = act && tick_i && armed_q && !cu_q && due;
        wrap_hit = act && tick_i && armed_q && wrap_q && mode_i.nar && !mode_i.per
                   && (&count_i[HALF_W-1:0]);
        if (hit)           ev = EV_MATCH;
        else if (wrap_hit) ev = EV_WRAP;
        else               ev = EV_IDLE;
        adv_o = !arm_i && (((ev == EV_MATCH) && per_live) || cu_q);
    end

    // Arming, wrap, catch-up flags and the registered pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            wrap_q   <= 1'b0;
            cu_q     <= 1'b0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= (ev != EV_IDLE);
            if (arm_i) begin
                armed_q <= 1'b1;
                wrap_q  <= 1'b1;
                cu_q    <= 1'b0;
            end else begin
                if (ev == EV_MATCH) begin
                    if (per_live) cu_q    <= behind_next;
                    else          armed_q <= 1'b0;
                end else if (cu_q) begin
                    cu_q <= behind_next;
                end
                if (ev == EV_WRAP) begin
                    wrap_q <= 1'b0;
                end
            end
        end
    end

    assign expire_o = expire_q;

    // R11
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_q |-> ($past(tick_i) && $past(glb_en_i) && $past(mode_i.en)));

    // R2
    one_shot_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(expire_q)
         && !$past(mode_i.per, 2) && !$past(mode_i.nar, 2) && !$past(arm_i, 2))
        |-> !expire_q);

endmodule

// File: rtl/cmp_timer_chan.sv
// Comparator timer channel top.
// Joins configuration, storage and expiry logic for one event channel that
// watches an external main counter.
// Assumes: count_i is stable in the cycle it is sampled; tick_i marks the
// cycles in which the comparison is to be made.
module cmp_timer_chan
    import cmpt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   count_i,
    input  logic               tick_i,
    input  logic               glb_en_i,
    input  logic               cfg_wr_i,
    input  logic               cfg_en_i,
    input  logic               cfg_per_i,
    input  logic               cfg_nar_i,
    input  logic               cfg_setval_i,
    input  logic               cmp_wr_lo_i,
    input  logic               cmp_wr_hi_i,
    input  logic [CNT_W/2-1:0] cmp_wdata_i,
    output logic               expire_o,
    output logic [CNT_W-1:0]   cmp_o,
    output logic [CNT_W-1:0]   period_o,
    output logic               setval_o
);

    cmpt_mode_t       mode;
    logic             setval;
    logic             en_rise;
    logic             trunc;
    logic             adv;
    logic             arm;
    logic             cmp_wr_any;
    logic [CNT_W-1:0] cmp_val;
    logic [CNT_W-1:0] per_val;
    logic [CNT_W-1:0] sum_val;

    // Arming sources for the expiry logic
    always_comb begin
        cmp_wr_any = cmp_wr_lo_i || cmp_wr_hi_i;
        arm        = cmp_wr_any || en_rise;
    end

    cmpt_cfg_reg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_en_i     (cfg_en_i),
        .cfg_per_i    (cfg_per_i),
        .cfg_nar_i    (cfg_nar_i),
        .cfg_setval_i (cfg_setval_i),
        .cmp_wr_i     (cmp_wr_any),
        .mode_o       (mode),
        .setval_o     (setval),
        .en_rise_o    (en_rise),
        .trunc_o      (trunc)
    );

    cmpt_cmp_store #(.CNT_W(CNT_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .setval_i (setval),
        .wr_lo_i  (cmp_wr_lo_i),
        .wr_hi_i  (cmp_wr_hi_i),
        .wdata_i  (cmp_wdata_i),
        .trunc_i  (trunc),
        .adv_i    (adv),
        .cmp_o    (cmp_val),
        .per_o    (per_val),
        .sum_o    (sum_val)
    );

    cmpt_expiry #(.CNT_W(CNT_W)) u_exp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .count_i  (count_i),
        .glb_en_i (glb_en_i),
        .mode_i   (mode),
        .cmp_i    (cmp_val),
        .per_i    (per_val),
        .sum_i    (sum_val),
        .arm_i    (arm),
        .adv_o    (adv),
        .expire_o (expire_o)
    );

    assign cmp_o    = cmp_val;
    assign period_o = per_val;
    assign setval_o = setval;

endmodule

// File: tb/cmp_timer_chan_bench.sv
// Scoreboard bench: the driver queues the expected expire_o for each driven
// cycle, and the monitor compares after every rising edge.
module cmp_timer_chan_bench;

    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] count_i = '0;
    logic        tick_i = 1'b0;
    logic        glb_en_i = 1'b0;
    logic        cfg_wr_i = 1'b0;
    logic        cfg_en_i = 1'b0;
    logic        cfg_per_i = 1'b0;
    logic        cfg_nar_i = 1'b0;
    logic        cfg_setval_i = 1'b0;
    logic        cmp_wr_lo_i = 1'b0;
    logic        cmp_wr_hi_i = 1'b0;
    logic [31:0] cmp_wdata_i = '0;
    logic        expire_o;
    logic [63:0] cmp_o;
    logic [63:0] period_o;
    logic        setval_o;

    int    compared = 0;
    int    mismatched = 0;
    bit    gen = 1'b1;
    bit    exq[$];
    string tagq[$];
    bit    mon_e;
    string mon_t;

    always #(CLK_PER/2) clk = ~clk;

    cmp_timer_chan u_cmp_timer_chan (
        .clk          (clk),
        .rst_n        (rst_n),
        .count_i      (count_i),
        .tick_i       (tick_i),
        .glb_en_i     (glb_en_i),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_en_i     (cfg_en_i),
        .cfg_per_i    (cfg_per_i),
        .cfg_nar_i    (cfg_nar_i),
        .cfg_setval_i (cfg_setval_i),
        .cmp_wr_lo_i  (cmp_wr_lo_i),
        .cmp_wr_hi_i  (cmp_wr_hi_i),
        .cmp_wdata_i  (cmp_wdata_i),
        .expire_o     (expire_o),
        .cmp_o        (cmp_o),
        .period_o     (period_o),
        .setval_o     (setval_o)
    );

    // Drive one cycle at the falling edge and queue the expected pulse
    task automatic cyc(input bit tk, input logic [63:0] cn, input bit cw,
                       input bit en, input bit per, input bit nar, input bit sv,
                       input bit wl, input bit wh, input logic [31:0] wd,
                       input bit ex, input string tag);
        @(negedge clk);
        glb_en_i     = gen;
        tick_i       = tk;
        count_i      = cn;
        cfg_wr_i     = cw;
        cfg_en_i     = en;
        cfg_per_i    = per;
        cfg_nar_i    = nar;
        cfg_setval_i = sv;
        cmp_wr_lo_i  = wl;
        cmp_wr_hi_i  = wh;
        cmp_wdata_i  = wd;
        exq.push_back(ex);
        tagq.push_back(tag);
    endtask

    task automatic tick(input logic [63:0] cn, input bit ex, input string tag);
        cyc(1'b1, cn, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, ex, tag);
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, count_i, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0, tag);
    endtask

    task automatic cfg(input bit en, input bit per, input bit nar, input bit sv, input string tag);
        cyc(1'b0, count_i, 1'b1, en, per, nar, sv, 1'b0, 1'b0, '0, 1'b0, tag);
    endtask

    task automatic wr_lo(input logic [31:0] d, input string tag);
        cyc(1'b0, count_i, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, d, 1'b0, tag);
    endtask

    task automatic wr_hi(input logic [31:0] d, input string tag);
        cyc(1'b0, count_i, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, d, 1'b0, tag);
    endtask

    // Readback after the edge that captured the last driven cycle
    task automatic rb_check(input logic [63:0] ecmp, input logic [63:0] eper,
                            input bit esv, input string tag);
        @(posedge clk);
        #(CLK_PER/4);
        compared++;
        if (cmp_o !== ecmp || period_o !== eper || setval_o !== esv) begin
            mismatched++;
            $display("FAIL %s cmp=%h per=%h sv=%0b expected cmp=%h per=%h sv=%0b",
                     tag, cmp_o, period_o, setval_o, ecmp, eper, esv);
        end
    endtask

    // Monitor: compare each queued expectation with expire_o
    always @(posedge clk) begin
        #(CLK_PER/4);
        if (exq.size() > 0) begin
            mon_e = exq.pop_front();
            mon_t = tagq.pop_front();
            compared++;
            if (expire_o !== mon_e) begin
                mismatched++;
                $display("FAIL %s expire_o actual=%0b expected=%0b", mon_t, expire_o, mon_e);
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rb_check({64{1'b1}}, 64'h0, 1'b0, "R1");
        compared++;
        if (expire_o !== 1'b0) begin
            mismatched++;
            $display("FAIL R1 expire_o actual=%0b expected=0", expire_o);
        end
        gen = 1'b1;

        // R2 wide one-shot
        cfg(1, 0, 0, 0, "R2");
        wr_lo(32'd100, "R6");
        wr_hi(32'd0, "R6");
        rb_check(64'd100, 64'd0, 1'b0, "R6");
        tick(64'd98, 1'b0, "R2");
        tick(64'd99, 1'b0, "R2");
        tick(64'd100, 1'b1, "R2");
        tick(64'd101, 1'b0, "R2");
        tick(64'd102, 1'b0, "R2");

        // R3 signed difference, counter well past comparator
        wr_lo(32'd50, "R3");
        tick(64'd200, 1'b1, "R3");
        tick(64'd201, 1'b0, "R3");

        // R3 narrow mode compares low halves only
        cfg(1, 0, 1, 0, "R3");
        wr_hi(32'd5, "R3");
        rb_check(64'h5_0000_0032, 64'd0, 1'b0, "R3");
        tick(64'h40, 1'b1, "R3");
        tick(64'h41, 1'b0, "R3");

        // R9 narrow selection clears upper halves
        cfg(1, 0, 1, 0, "R9");
        rb_check(64'h32, 64'd0, 1'b0, "R9");

        // R8 direct-load bit set, then cleared by a write
        cfg(1, 1, 0, 1, "R8");
        rb_check(64'h32, 64'd0, 1'b1, "R8");
        wr_lo(32'd1000, "R6");
        rb_check(64'd1000, 64'd1000, 1'b0, "R8");
        wr_lo(32'd10, "R6");
        rb_check(64'd1000, 64'd10, 1'b0, "R6");

        // R4 periodic advance
        tick(64'd999, 1'b0, "R4");
        tick(64'd1000, 1'b1, "R4");
        tick(64'd1005, 1'b0, "R4");
        tick(64'd1010, 1'b1, "R4");
        tick(64'd1020, 1'b1, "R4");
        rb_check(64'd1030, 64'd10, 1'b0, "R4");

        // R5 catch-up after a counter jump: one pulse, then one period per clock
        tick(64'd1065, 1'b1, "R5");
        idle("R5");
        idle("R5");
        idle("R5");
        rb_check(64'd1070, 64'd10, 1'b0, "R5");
        tick(64'd1070, 1'b1, "R5");

        // R7 wide high-half clamp
        wr_hi(32'hFFFF_FFFF, "R7");
        rb_check(64'd1080, 64'h7FFF_FFFF_0000_000A, 1'b0, "R7");

        // R6 direct load writes both comparator and period halves
        cfg(1, 1, 0, 1, "R6");
        wr_hi(32'd2, "R6");
        rb_check(64'h2_0000_0438, 64'h2_0000_000A, 1'b0, "R6");

        // R9 truncation of both registers
        cfg(1, 1, 1, 0, "R9");
        rb_check(64'h438, 64'hA, 1'b0, "R9");

        // R7 narrow low-half clamp
        wr_lo(32'hFFFF_FFFF, "R7");
        rb_check(64'h438, 64'h7FFF_FFFF, 1'b0, "R7");

        // R10 narrow one-shot wrap event, then the real match
        cfg(1, 0, 1, 0, "R10");
        wr_lo(32'h10, "R10");
        tick(64'hFFFF_FFF0, 1'b0, "R10");
        tick(64'hFFFF_FFFF, 1'b1, "R10");
        tick(64'h1_0000_0000, 1'b0, "R10");
        tick(64'h1_0000_000F, 1'b0, "R10");
        tick(64'h1_0000_0010, 1'b1, "R10");
        tick(64'h1_0000_0011, 1'b0, "R10");
        wr_lo(32'h20, "R10");
        tick(64'h1_FFFF_FFFF, 1'b1, "R10");
        tick(64'h2_0000_0020, 1'b1, "R10");

        // R11 global enable, tick and channel enable gating
        cfg(1, 0, 0, 0, "R11");
        wr_lo(32'h500, "R11");
        gen = 1'b0;
        tick(64'h600, 1'b0, "R11");
        gen = 1'b1;
        idle("R11");
        tick(64'h600, 1'b1, "R11");
        cfg(0, 0, 0, 0, "R11");
        wr_lo(32'h700, "R11");
        tick(64'h800, 1'b0, "R11");
        cfg(1, 0, 0, 0, "R11");
        tick(64'h800, 1'b1, "R11");

        // R12 periodic with zero period fires once
        cfg(1, 1, 0, 1, "R12");
        wr_lo(32'h900, "R12");
        wr_lo(32'h0, "R12");
        rb_check(64'h900, 64'h0, 1'b0, "R12");
        tick(64'h900, 1'b1, "R12");
        tick(64'h950, 1'b0, "R12");
        tick(64'h960, 1'b0, "R12");

        idle("end");
        repeat (3) @(posedge clk);
        #(CLK_PER/2);
        summary();
    end

endmodule